// File: doc/BRIEF.md
# Processor Priority Assignment Unit

This block sits next to a hardware task scheduler in a multiprocessor system and decides how urgently each processor should be served on the shared bus. For every processor it receives the priority of the task that processor is running now and a flag telling whether the processor is running anything at all. On an update strobe it sorts the processors by the urgency of their current tasks and gives each one a distinct rank. A processor's bus priority therefore follows the task it is executing instead of being fixed at design time.

The ranks leave on a dedicated priority bus, a packed vector with one rank field per processor and a one-cycle valid pulse, which the bus arbiter latches. The system bus does not carry them. The scheduler pulses the strobe whenever the task running on any processor changes. The processor count and the task priority width are parameters; three processors is the default.

Top module: `ppa_top`

## Requirements
- R1: While rst_ni is low and after its release until the first update, processor i holds rank i and rank_valid_o is 0.
- R2: Ranks computed from the inputs present in the cycle update_i is high appear on rank_o on the next rising edge, and rank_valid_o is high for exactly that one cycle; rank_valid_o is low in every cycle that does not follow an update_i cycle.
- R3: In a cycle without update_i, rank_o does not change, whatever task_prio_i and busy_i do.
- R4: Among busy processors, the one with the numerically lower task priority gets the numerically lower (better) rank; rank 0 is the best.
- R5: Two busy processors with equal task priority are ordered by index: the lower index gets the better rank.
- R6: Every idle processor (busy_i bit 0) gets a worse rank than every busy processor.
- R7: The ranks are always a permutation of 0..N_CPUS-1: no two processors share a rank.
- R8: The task priority of an idle processor is ignored; idle processors are ordered by index, lower index better.
- R9: Field layout: the task priority of processor i is task_prio_i[i*PRIO_W +: PRIO_W], its busy flag is busy_i[i], and its rank is rank_o[i*RANK_W +: RANK_W], with RANK_W = clog2(N_CPUS) (at least 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| task_prio_i | input | N_CPUS*PRIO_W | Priority of the task running on each processor, lower value more urgent |
| busy_i | input | N_CPUS | Per-processor flag, 1 = running a task, 0 = idle |
| update_i | input | 1 | Strobe: recompute ranks from the present inputs |
| rank_o | output | N_CPUS*RANK_W | Priority bus: rank of each processor, 0 best |
| rank_valid_o | output | 1 | One-cycle pulse marking a fresh rank_o |

## Verification
A wrong comparison or count shows up on rank_o in the cycle after the strobe as a duplicated rank or a swapped pair, so the sweep compares the whole rank vector against an arithmetic ordering for every combination of busy mask and priorities over a small priority range. Errors in the tie and idle cases show only when priorities coincide or processors are idle, so those patterns are part of the sweep. A register that loads without the strobe shows as a changed rank one cycle after the inputs move, which the bench checks by changing the inputs while holding the strobe low.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  parameter int unsigned PPA_DEF_CPUS   = 3;
  parameter int unsigned PPA_DEF_PRIO_W = 8;

  function automatic int unsigned rank_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ppa_key_gen.sv
// Builds a sort key per processor: idle flag in the MSB, priority below.
// Idle processors get a zero priority field so their task priority is ignored.
module ppa_key_gen #(
  parameter int unsigned N_CPUS = ppa_pkg::PPA_DEF_CPUS,
  parameter int unsigned PRIO_W = ppa_pkg::PPA_DEF_PRIO_W,
  localparam int unsigned KEY_W = PRIO_W + 1
) (
  input  logic [N_CPUS*PRIO_W-1:0] task_prio_i,
  input  logic [N_CPUS-1:0]        busy_i,
  output logic [N_CPUS*KEY_W-1:0]  key_o
);
  for (genvar i = 0; i < N_CPUS; i++) begin : g_key
    assign key_o[i*KEY_W +: KEY_W] = busy_i[i]
                                   ? {1'b0, task_prio_i[i*PRIO_W +: PRIO_W]}
                                   : {1'b1, {PRIO_W{1'b0}}};
  end
endmodule

// File: rtl/ppa_beat_matrix.sv
// beat_o[i*N_CPUS + j] = processor j outranks processor i.
module ppa_beat_matrix #(
  parameter int unsigned N_CPUS = ppa_pkg::PPA_DEF_CPUS,
  parameter int unsigned KEY_W  = ppa_pkg::PPA_DEF_PRIO_W + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CPUS*KEY_W-1:0]   key_i,
  output logic [N_CPUS*N_CPUS-1:0]  beat_o
);
  for (genvar i = 0; i < N_CPUS; i++) begin : g_row
    for (genvar j = 0; j < N_CPUS; j++) begin : g_col
      if (i == j) begin : g_diag
        assign beat_o[i*N_CPUS + j] = 1'b0;
      end else if (j < i) begin : g_lower
        // lower index wins ties
        assign beat_o[i*N_CPUS + j] = key_i[j*KEY_W +: KEY_W] <= key_i[i*KEY_W +: KEY_W];
      end else begin : g_upper
        assign beat_o[i*N_CPUS + j] = key_i[j*KEY_W +: KEY_W] <  key_i[i*KEY_W +: KEY_W];
      end

      if (j > i) begin : g_chk
        // R7: every pair is strictly ordered, exactly one side wins
        a_r7_pair_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
          beat_o[i*N_CPUS + j] != beat_o[j*N_CPUS + i]);
      end
    end
  end
endmodule

// File: rtl/ppa_rank_count.sv
// Rank of processor i = number of processors that outrank it.
module ppa_rank_count #(
  parameter int unsigned N_CPUS = ppa_pkg::PPA_DEF_CPUS,
  localparam int unsigned RANK_W = ppa_pkg::rank_width(N_CPUS)
) (
  input  logic [N_CPUS*N_CPUS-1:0] beat_i,
  output logic [N_CPUS*RANK_W-1:0] rank_o
);
  for (genvar i = 0; i < N_CPUS; i++) begin : g_cnt
    logic [RANK_W:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < N_CPUS; j++) begin
        acc = acc + {{RANK_W{1'b0}}, beat_i[i*N_CPUS + j]};
      end
    end
    assign rank_o[i*RANK_W +: RANK_W] = acc[RANK_W-1:0];
  end
endmodule

// File: rtl/ppa_top.sv
module ppa_top #(
  parameter int unsigned N_CPUS = ppa_pkg::PPA_DEF_CPUS,
  parameter int unsigned PRIO_W = ppa_pkg::PPA_DEF_PRIO_W,
  localparam int unsigned RANK_W = ppa_pkg::rank_width(N_CPUS),
  localparam int unsigned KEY_W  = PRIO_W + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CPUS*PRIO_W-1:0]  task_prio_i,
  input  logic [N_CPUS-1:0]         busy_i,
  input  logic                      update_i,
  output logic [N_CPUS*RANK_W-1:0]  rank_o,
  output logic                      rank_valid_o
);
  logic [N_CPUS*KEY_W-1:0]  key;
  logic [N_CPUS*N_CPUS-1:0] beat;
  logic [N_CPUS*RANK_W-1:0] rank_nxt;
  logic [N_CPUS*RANK_W-1:0] rank_rst;

  ppa_key_gen #(.N_CPUS(N_CPUS), .PRIO_W(PRIO_W)) u_key (
    .task_prio_i(task_prio_i),
    .busy_i     (busy_i),
    .key_o      (key)
  );

  ppa_beat_matrix #(.N_CPUS(N_CPUS), .KEY_W(KEY_W)) u_mat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .key_i (key),
    .beat_o(beat)
  );

  ppa_rank_count #(.N_CPUS(N_CPUS)) u_cnt (
    .beat_i(beat),
    .rank_o(rank_nxt)
  );

  for (genvar i = 0; i < N_CPUS; i++) begin : g_rst
    assign rank_rst[i*RANK_W +: RANK_W] = RANK_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rank_o       <= rank_rst;
      rank_valid_o <= 1'b0;
    end else begin
      rank_valid_o <= update_i;
      if (update_i) rank_o <= rank_nxt;
    end
  end

  // R2: pulse follows the strobe, and only the strobe
  a_r2_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> rank_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> !rank_valid_o);
  // R3: priority bus frozen between strobes
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(rank_o));

  for (genvar k = 0; k < N_CPUS; k++) begin : g_perm
    logic [N_CPUS-1:0] holds;
    for (genvar i = 0; i < N_CPUS; i++) begin : g_h
      assign holds[i] = rank_o[i*RANK_W +: RANK_W] == RANK_W'(k);
    end
    // R7: each rank value held by exactly one processor
    a_r7_unique: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(holds) == 1);
  end

  for (genvar i = 0; i < N_CPUS; i++) begin : g_ord_i
    for (genvar j = 0; j < N_CPUS; j++) begin : g_ord_j
      if (i != j) begin : g_pair
        // R4: more urgent busy task -> better rank
        a_r4_urgency: assert property (@(posedge clk_i) disable iff (!rst_ni)
          update_i && busy_i[i] && busy_i[j] &&
          task_prio_i[i*PRIO_W +: PRIO_W] < task_prio_i[j*PRIO_W +: PRIO_W]
          |=> rank_o[i*RANK_W +: RANK_W] < rank_o[j*RANK_W +: RANK_W]);
        // R6: busy beats idle
        a_r6_idle_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
          update_i && busy_i[i] && !busy_i[j]
          |=> rank_o[i*RANK_W +: RANK_W] < rank_o[j*RANK_W +: RANK_W]);
      end
      if (i < j) begin : g_tie
        // R5: equal priority, lower index first
        a_r5_tie_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
          update_i && busy_i[i] && busy_i[j] &&
          task_prio_i[i*PRIO_W +: PRIO_W] == task_prio_i[j*PRIO_W +: PRIO_W]
          |=> rank_o[i*RANK_W +: RANK_W] < rank_o[j*RANK_W +: RANK_W]);
        // R8: idle pair ordered by index
        a_r8_idle_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
          update_i && !busy_i[i] && !busy_i[j]
          |=> rank_o[i*RANK_W +: RANK_W] < rank_o[j*RANK_W +: RANK_W]);
      end
    end
  end
endmodule

// File: tb/sim_ppa_top.sv
module sim_ppa_top;
  localparam int N  = 3;
  localparam int PW = 8;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N*PW-1:0] prio = '0;
  logic [N-1:0]  busy = '0;
  logic          upd = 1'b0;
  logic [N*RW-1:0] rank;
  logic          rvalid;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ppa_top #(.N_CPUS(N), .PRIO_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .task_prio_i(prio), .busy_i(busy),
    .update_i(upd), .rank_o(rank), .rank_valid_o(rvalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected ranks from the ordering rules (R4, R5, R6, R8), field layout per R9
  function automatic logic [N*RW-1:0] exp_rank(input logic [N*PW-1:0] p, input logic [N-1:0] b);
    logic [N*RW-1:0] r;
    for (int i = 0; i < N; i++) begin
      int cnt = 0;
      int ki = b[i] ? int'(p[i*PW +: PW]) : 1000;
      for (int j = 0; j < N; j++) begin
        int kj = b[j] ? int'(p[j*PW +: PW]) : 1000;
        if (j != i && (kj < ki || (kj == ki && j < i))) cnt++;
      end
      r[i*RW +: RW] = RW'(cnt);
    end
    return r;
  endfunction

  function automatic string tag_for(input logic [N*PW-1:0] p, input logic [N-1:0] b);
    int nb = $countones(b);
    if (nb == 0) return "R8";
    if (nb < N) return (nb == N-1) ? "R6" : "R8";
    if (p[0 +: PW] == p[PW +: PW] || p[PW +: PW] == p[2*PW +: PW] || p[0 +: PW] == p[2*PW +: PW])
      return "R5";
    return "R4";
  endfunction

  function automatic logic perm_ok(input logic [N*RW-1:0] r);
    logic [3:0] seen = '0;
    for (int i = 0; i < N; i++) begin
      if (int'(r[i*RW +: RW]) >= N) return 1'b0;
      seen[r[i*RW +: RW]] = 1'b1;
    end
    return seen[N-1:0] == '1;
  endfunction

  task automatic apply(input logic [N*PW-1:0] p, input logic [N-1:0] b);
    @(negedge clk);
    prio = p; busy = b; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    check("R2 valid", 32'(rvalid), 32'd1);
    check(tag_for(p, b), 32'(rank), 32'(exp_rank(p, b)));
    check("R7 permutation", 32'(perm_ok(rank)), 32'd1);
  endtask

  initial begin
    logic [N*RW-1:0] held;
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 rank", 32'(rank), 32'(6'b10_01_00));
    check("R1 valid", 32'(rvalid), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 rank after release", 32'(rank), 32'(6'b10_01_00));
    check("R2 no pulse without strobe", 32'(rvalid), 32'd0);

    // Sweep: every busy mask and priorities 0..3 on each processor (R4 R5 R6 R8 R9)
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 4; a++) begin
        for (int c = 0; c < 4; c++) begin
          for (int d = 0; d < 4; d++) begin
            apply({8'(d), 8'(c), 8'(a)}, 3'(m));
          end
        end
      end
    end

    // Wide priority values, R4
    apply({8'd255, 8'd0, 8'd128}, 3'b111);
    // Idle priority ignored, R8: idle prio 0 must not beat busy 200
    apply({8'd0, 8'd200, 8'd0}, 3'b010);
    check("R8 idle prio ignored", 32'(rank), 32'(6'b10_00_01));

    // R2: pulse lasts one cycle
    @(negedge clk);
    check("R2 pulse width", 32'(rvalid), 32'd0);

    // R3: inputs change without strobe, ranks hold
    held = rank;
    prio = {8'd0, 8'd1, 8'd2}; busy = 3'b111;
    repeat (3) @(negedge clk);
    check("R3 hold", 32'(rank), 32'(held));
    check("R3 no pulse", 32'(rvalid), 32'd0);

    // R1: async reset mid-run restores index ranks
    apply({8'd0, 8'd1, 8'd2}, 3'b111);
    check("R4 reversed order", 32'(rank), 32'(6'b00_01_10));
    #3 rst_n = 1'b0;
    #3 check("R1 async reset", 32'(rank), 32'(6'b10_01_00));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule